// File: doc/BRIEF.md
# Asynchronous Flash Write Strober

This block runs one asynchronous write cycle at a time on the pins of a parallel flash command interface. It runs entirely from the host clock. A request carries an address, a data word and a style bit, and arrives over a valid/ready port. The word can be a command or program data; the block does not interpret it. The block drives the strobes, the address pins and the data bus in a fixed order. Each phase lasts a programmable number of host clock cycles. When the strobes are back at rest, the block gives a one-cycle completion pulse.

Two write styles are supported. In the plain style (style bit 0), the latch strobe is held low for the whole cycle, so the rising write strobe captures both the address and the data. In the latched style (style bit 1), a separate low pulse on the latch strobe captures the address first. The write strobe pulse then follows and captures only the data. In both styles the write strobe rises before chip enable, so the write-strobe edge is always the one that captures. Output enable is held high and output disable low for the entire cycle, and the memory clock pin is held at a constant low.

After each write, the block waits through a programmable recovery gap with chip enable high before it takes the next request.

Top module: `flash_wr_strober`

## Requirements
- R1: After synchronous reset, the block drives these levels: chip enable, write enable and latch enable high (inactive); output enable high; output disable low; memory clock low; data driver off; ready high; done low.
- R2: A request is taken only in a cycle where ready is high. Ready stays low from the accepting edge until the recovery gap has ended. A valid request held high while ready is low starts no cycle.
- R3: In the plain style, chip enable and latch enable go low together. After cfg_setup cycles the write strobe falls and stays low for cfg_pulse cycles. It then rises, and cfg_hold cycles later chip enable and latch enable rise together.
- R4: In the latched style, chip enable goes low with the latch strobe still high for cfg_setup cycles. The latch strobe is then low for cfg_latch cycles. It rises on the same edge where the write strobe falls. The write strobe is low for cfg_pulse cycles, and chip enable rises cfg_hold cycles after the write strobe rises. The latch strobe is never low together with the write strobe.
- R5: While chip enable is low, the address pins show the request address and do not change.
- R6: The data driver is on in every cycle where chip enable is low, and off otherwise. While it is on, the data pins show the request word. It is still on in the cycle where the write strobe rises.
- R7: Output enable stays high, output disable low and the memory clock low in every cycle.
- R8: The write strobe never rises in the same cycle as chip enable, and it is high whenever chip enable rises.
- R9: Done is high for exactly one cycle: the first cycle with chip enable back high. In that cycle the write strobe is high and the data driver is off.
- R10: Ready returns exactly cfg_gap + 1 cycles after the done cycle. A gap of 0 means ready returns in the cycle right after done.
- R11: A phase length of 0 for setup, latch, pulse or hold is treated as 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block is idle and will take a request |
| req_addr | input | AW | Address for the write |
| req_data | input | DW | Command or program word |
| req_latch | input | 1 | Style: 0 plain, 1 latched |
| cfg_setup | input | CW | Cycles with chip enable low before the next strobe |
| cfg_latch | input | CW | Latch strobe low width (latched style) |
| cfg_pulse | input | CW | Write strobe low width |
| cfg_hold | input | CW | Cycles from write strobe rise to chip enable rise |
| cfg_gap | input | CW | Recovery cycles after done before ready |
| done | output | 1 | One-cycle completion pulse |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_le_n | output | 1 | Address latch strobe, active low |
| fl_oe_n | output | 1 | Output enable, active low (held high) |
| fl_od_n | output | 1 | Output disable, active low (held low) |
| fl_clk | output | 1 | Memory clock pin, held low |
| fl_addr | output | AW | Address pins |
| fl_dq_o | output | DW | Data bus value |
| fl_dq_oe | output | 1 | Data bus driver enable |

## Verification
The bench builds the block with AW=16, DW=16 and CW=4, so a phase count can be at most 15. With these values, both the zero-clamp case and the full-scale case of every phase counter can be reached in short runs. It runs both write styles with minimum, mixed and all-ones phase lengths, and recovery gaps of 0, 1 and 15. Between requests it varies the address and data patterns. It also holds a request valid while the block is busy, to show that a busy block starts no cycle.

// File: rtl/fws_pkg.sv
package fws_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_LATCH,
        PH_PULSE,
        PH_HOLD,
        PH_DONE,
        PH_GAP
    } phase_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic le_n;
        logic drive;
    } strobe_t;

    // True while the chip is selected for a write.
    function automatic logic phase_active(phase_e ph);
        return (ph == PH_SETUP) || (ph == PH_LATCH) ||
               (ph == PH_PULSE) || (ph == PH_HOLD);
    endfunction

    // Pin levels for a phase; lm selects the latched style.
    function automatic strobe_t strobe_for(phase_e ph, logic lm);
        strobe_t s;
        logic    act;
        act     = phase_active(ph);
        s.ce_n  = !act;
        s.we_n  = (ph != PH_PULSE);
        s.le_n  = lm ? (ph != PH_LATCH) : !act;
        s.drive = act;
        return s;
    endfunction

endpackage

// File: rtl/fws_timer.sv
module fws_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/fws_seq.sv
module fws_seq
    import fws_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          latch_mode,
    input  logic [CW-1:0] cfg_setup,
    input  logic [CW-1:0] cfg_latch,
    input  logic [CW-1:0] cfg_pulse,
    input  logic [CW-1:0] cfg_hold,
    input  logic [CW-1:0] cfg_gap,
    output phase_e        phase,
    output logic          accept
);
    phase_e        ph_q;
    phase_e        ph_d;
    logic          ld;
    logic [CW-1:0] ld_val;
    logic          expired;

    // Reload value for a phase of v cycles, with 0 clamped to 1.
    function automatic logic [CW-1:0] reload(input logic [CW-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    fws_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .load_val (ld_val),
        .expired  (expired)
    );

    always_comb begin
        ph_d   = ph_q;
        ld     = 1'b0;
        ld_val = '0;
        case (ph_q)
            PH_IDLE: begin
                if (req_valid) begin
                    ph_d   = PH_SETUP;
                    ld     = 1'b1;
                    ld_val = reload(cfg_setup);
                end
            end
            PH_SETUP: begin
                if (expired) begin
                    ld = 1'b1;
                    if (latch_mode) begin
                        ph_d   = PH_LATCH;
                        ld_val = reload(cfg_latch);
                    end else begin
                        ph_d   = PH_PULSE;
                        ld_val = reload(cfg_pulse);
                    end
                end
            end
            PH_LATCH: begin
                if (expired) begin
                    ph_d   = PH_PULSE;
                    ld     = 1'b1;
                    ld_val = reload(cfg_pulse);
                end
            end
            PH_PULSE: begin
                if (expired) begin
                    ph_d   = PH_HOLD;
                    ld     = 1'b1;
                    ld_val = reload(cfg_hold);
                end
            end
            PH_HOLD: begin
                if (expired) begin
                    ph_d = PH_DONE;
                end
            end
            PH_DONE: begin
                if (cfg_gap == '0) begin
                    ph_d = PH_IDLE;
                end else begin
                    ph_d   = PH_GAP;
                    ld     = 1'b1;
                    ld_val = cfg_gap - 1'b1;
                end
            end
            PH_GAP: begin
                if (expired) begin
                    ph_d = PH_IDLE;
                end
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_IDLE;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign phase  = ph_q;
    assign accept = (ph_q == PH_IDLE) && req_valid;
endmodule

// File: rtl/fws_pins.sv
module fws_pins
    import fws_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic          req_latch,
    input  phase_e        phase,
    output logic          latch_mode,
    output logic          ce_n,
    output logic          we_n,
    output logic          le_n,
    output logic          oe_n,
    output logic          od_n,
    output logic          dq_oe,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] dq_o
);
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          mode_q;
    logic          oe_n_q;
    logic          od_n_q;
    strobe_t       stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
            mode_q <= 1'b0;
            oe_n_q <= 1'b1;
            od_n_q <= 1'b0;
        end else begin
            oe_n_q <= 1'b1;
            od_n_q <= 1'b0;
            if (accept) begin
                addr_q <= req_addr;
                data_q <= req_data;
                mode_q <= req_latch;
            end
        end
    end

    assign stb        = strobe_for(phase, mode_q);
    assign latch_mode = mode_q;
    assign ce_n       = stb.ce_n;
    assign we_n       = stb.we_n;
    assign le_n       = stb.le_n;
    assign oe_n       = oe_n_q;
    assign od_n       = od_n_q;
    // Driver turns on only while the read path is held off.
    assign dq_oe      = stb.drive && oe_n_q && !od_n_q;
    assign addr_o     = addr_q;
    assign dq_o       = data_q;
endmodule

// File: rtl/flash_wr_strober.sv
module flash_wr_strober
    import fws_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 32,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic          req_latch,
    input  logic [CW-1:0] cfg_setup,
    input  logic [CW-1:0] cfg_latch,
    input  logic [CW-1:0] cfg_pulse,
    input  logic [CW-1:0] cfg_hold,
    input  logic [CW-1:0] cfg_gap,
    output logic          done,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_le_n,
    output logic          fl_oe_n,
    output logic          fl_od_n,
    output logic          fl_clk,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dq_o,
    output logic          fl_dq_oe
);
    phase_e phase;
    logic   accept;
    logic   latch_mode;

    fws_seq #(.CW(CW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .latch_mode (latch_mode),
        .cfg_setup  (cfg_setup),
        .cfg_latch  (cfg_latch),
        .cfg_pulse  (cfg_pulse),
        .cfg_hold   (cfg_hold),
        .cfg_gap    (cfg_gap),
        .phase      (phase),
        .accept     (accept)
    );

    fws_pins #(.AW(AW), .DW(DW)) u_pins (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .req_addr   (req_addr),
        .req_data   (req_data),
        .req_latch  (req_latch),
        .phase      (phase),
        .latch_mode (latch_mode),
        .ce_n       (fl_ce_n),
        .we_n       (fl_we_n),
        .le_n       (fl_le_n),
        .oe_n       (fl_oe_n),
        .od_n       (fl_od_n),
        .dq_oe      (fl_dq_oe),
        .addr_o     (fl_addr),
        .dq_o       (fl_dq_o)
    );

    assign req_ready = (phase == PH_IDLE);
    assign done      = (phase == PH_DONE);
    assign fl_clk    = 1'b0;
endmodule

// File: rtl/fws_chk.sv
module fws_chk #(
    parameter int AW = 24,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic          done,
    input logic          fl_ce_n,
    input logic          fl_we_n,
    input logic          fl_oe_n,
    input logic          fl_od_n,
    input logic          fl_clk,
    input logic [AW-1:0] fl_addr,
    input logic [DW-1:0] fl_dq_o,
    input logic          fl_dq_oe
);
    a_r7_read_path_off: assert property (@(posedge clk) disable iff (rst)
        fl_oe_n && !fl_od_n && !fl_clk);

    a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> fl_ce_n);

    a_r2_accept_selects: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !fl_ce_n);

    a_r8_we_low_inside_ce: assert property (@(posedge clk) disable iff (rst)
        !fl_we_n |-> !fl_ce_n);

    a_r8_ce_rises_after_we: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_ce_n) |-> fl_we_n && $past(fl_we_n));

    a_r5_addr_stable: assert property (@(posedge clk) disable iff (rst)
        !fl_ce_n && $past(!fl_ce_n) |-> $stable(fl_addr));

    a_r6_data_stable: assert property (@(posedge clk) disable iff (rst)
        fl_dq_oe && $past(fl_dq_oe) |-> $stable(fl_dq_o));

    a_r6_driven_at_we_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_we_n) |-> fl_dq_oe && !fl_ce_n);

    a_r9_done_clean: assert property (@(posedge clk) disable iff (rst)
        done |-> fl_ce_n && fl_we_n && !fl_dq_oe);

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind flash_wr_strober fws_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .fl_ce_n   (fl_ce_n),
    .fl_we_n   (fl_we_n),
    .fl_oe_n   (fl_oe_n),
    .fl_od_n   (fl_od_n),
    .fl_clk    (fl_clk),
    .fl_addr   (fl_addr),
    .fl_dq_o   (fl_dq_o),
    .fl_dq_oe  (fl_dq_oe)
);

// File: tb/sim_flash_wr_strober.sv
module sim_flash_wr_strober;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          req_latch = 1'b0;
    logic [CW-1:0] cfg_setup = 4'd1;
    logic [CW-1:0] cfg_latch = 4'd1;
    logic [CW-1:0] cfg_pulse = 4'd1;
    logic [CW-1:0] cfg_hold = 4'd1;
    logic [CW-1:0] cfg_gap = 4'd0;
    logic          done;
    logic          fl_ce_n, fl_we_n, fl_le_n, fl_oe_n, fl_od_n, fl_clk;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_dq_o;
    logic          fl_dq_oe;

    always #5 clk = ~clk;

    flash_wr_strober #(.AW(AW), .DW(DW), .CW(CW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_latch(req_latch),
        .cfg_setup(cfg_setup), .cfg_latch(cfg_latch), .cfg_pulse(cfg_pulse),
        .cfg_hold(cfg_hold), .cfg_gap(cfg_gap), .done(done),
        .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_le_n(fl_le_n),
        .fl_oe_n(fl_oe_n), .fl_od_n(fl_od_n), .fl_clk(fl_clk),
        .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe)
    );

    typedef struct {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic          m;
        int            s, l, p, h, g;
    } exp_t;

    exp_t q[$];
    int   nchk = 0;
    int   nerr = 0;
    bit   finished = 1'b0;

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int clamp1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // Driver: waits for ready, programs the phases, queues the expectation.
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic m,
                      input int s, input int l, input int p, input int h, input int g,
                      input bit poke);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cfg_setup = CW'(s); cfg_latch = CW'(l); cfg_pulse = CW'(p);
        cfg_hold = CW'(h); cfg_gap = CW'(g);
        req_addr = a; req_data = d; req_latch = m;
        e.a = a; e.d = d; e.m = m;
        e.s = clamp1(s); e.l = clamp1(l); e.p = clamp1(p); e.h = clamp1(h); e.g = g;
        q.push_back(e);
        req_valid = 1'b1;
        @(negedge clk);
        if (poke) begin
            // R2: valid held with other values while busy must start nothing
            req_addr = ~a; req_data = ~d;
            @(negedge clk);
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    // Monitor: measures each pin cycle and compares with the queued item.
    exp_t cur;
    bit   in_op = 1'b0;
    int   ce_c, we_c, le_c, su_c, ho_c, ov_c, late_c, pre_c;
    int   gap_wait = -1;
    int   gap_exp = 0;
    bit   prev_done = 1'b0;

    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(fl_oe_n && !fl_od_n && !fl_clk, "R7 read path off",
                  {fl_oe_n, fl_od_n, fl_clk}, 3'b100);
            if (done && prev_done) check(1'b0, "R9 done longer than one cycle", 2, 1);
            prev_done = done;
            if (!fl_ce_n) begin
                if (!in_op) begin
                    if (q.size() == 0) begin
                        check(1'b0, "R2 cycle started with no accepted request", 1, 0);
                        cur = '{a: '0, d: '0, m: 1'b0, s: 0, l: 0, p: 0, h: 0, g: 0};
                    end else begin
                        cur = q.pop_front();
                    end
                    in_op = 1'b1;
                    ce_c = 0; we_c = 0; le_c = 0; su_c = 0; ho_c = 0;
                    ov_c = 0; late_c = 0; pre_c = 0;
                    gap_wait = -1;
                end
                ce_c++;
                if (!fl_we_n) we_c++;
                else if (we_c == 0) su_c++;
                else ho_c++;
                if (!fl_le_n) begin
                    le_c++;
                    if (!fl_we_n) ov_c++;
                    if (we_c > 0) late_c++;
                end else if (le_c == 0 && we_c == 0) begin
                    pre_c++;
                end
                check(fl_addr == cur.a, "R5 address on pins", fl_addr, cur.a);
                check(fl_dq_oe == 1'b1, "R6 driver on while selected", fl_dq_oe, 1);
                check(fl_dq_o == cur.d, "R6 data on pins", fl_dq_o, cur.d);
                check(!req_ready, "R2 ready low while busy", req_ready, 0);
            end else begin
                if (!fl_we_n) check(1'b0, "R8 write strobe low outside chip enable", 0, 1);
                check(fl_dq_oe == 1'b0, "R6 driver off while deselected", fl_dq_oe, 0);
                if (in_op) begin
                    in_op = 1'b0;
                    check(done == 1'b1, "R9 done with chip enable rise", done, 1);
                    check(fl_we_n && !fl_dq_oe, "R9 pins at rest on done",
                          {fl_we_n, fl_dq_oe}, 2'b10);
                    check(we_c == cur.p, "R3 write strobe width", we_c, cur.p);
                    check(ho_c == cur.h, "R3 hold before chip enable rise", ho_c, cur.h);
                    if (cur.m) begin
                        check(su_c == cur.s + cur.l, "R4 cycles before write strobe",
                              su_c, cur.s + cur.l);
                        check(pre_c == cur.s, "R4 setup before latch strobe", pre_c, cur.s);
                        check(le_c == cur.l, "R4 latch strobe width", le_c, cur.l);
                        check(ov_c == 0 && late_c == 0, "R4 latch strobe clear of write strobe",
                              ov_c + late_c, 0);
                    end else begin
                        check(su_c == cur.s, "R3 setup before write strobe", su_c, cur.s);
                        check(le_c == ce_c, "R3 latch strobe follows chip enable", le_c, ce_c);
                    end
                    check(ho_c >= 1, "R8 write strobe rises before chip enable", ho_c, 1);
                    gap_exp  = cur.g;
                    gap_wait = 0;
                end else if (gap_wait >= 0) begin
                    gap_wait++;
                    if (req_ready) begin
                        check(gap_wait == gap_exp + 1, "R10 recovery gap", gap_wait, gap_exp + 1);
                        gap_wait = -1;
                    end
                end else if (done) begin
                    check(1'b0, "R9 done without a cycle", 1, 0);
                end
            end
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1 reset levels
        check(fl_ce_n && fl_we_n && fl_le_n, "R1 strobes inactive in reset",
              {fl_ce_n, fl_we_n, fl_le_n}, 3'b111);
        check(fl_oe_n && !fl_od_n && !fl_clk, "R1 read path off in reset",
              {fl_oe_n, fl_od_n, fl_clk}, 3'b100);
        check(!fl_dq_oe && req_ready && !done, "R1 driver off, ready, no done",
              {fl_dq_oe, req_ready, done}, 3'b010);
        rst = 1'b0;

        wr(16'h1234, 16'hA5A5, 1'b0, 1, 1, 1, 1, 0, 1'b0);
        wr(16'h0001, 16'h00FF, 1'b0, 3, 1, 4, 2, 2, 1'b0);
        wr(16'hFFFE, 16'h5A5A, 1'b1, 2, 3, 2, 1, 1, 1'b0);
        wr(16'h8000, 16'h0001, 1'b1, 1, 1, 1, 1, 3, 1'b0);
        // R11 zero lengths act as one cycle
        wr(16'h0F0F, 16'hF0F0, 1'b0, 0, 0, 0, 0, 0, 1'b0);
        wr(16'h3C3C, 16'hC3C3, 1'b1, 0, 0, 0, 0, 1, 1'b0);
        // All-ones counts
        wr(16'hFFFF, 16'hFFFF, 1'b0, 15, 15, 15, 15, 15, 1'b0);
        wr(16'h0000, 16'h0000, 1'b1, 15, 15, 15, 15, 15, 1'b0);
        // R2 valid held while busy
        wr(16'h2468, 16'h1357, 1'b0, 2, 1, 2, 2, 2, 1'b1);
        wr(16'h1111, 16'h2222, 1'b1, 1, 2, 3, 2, 0, 1'b1);
        for (int i = 0; i < 6; i++) begin
            wr(AW'(16'h0100 * i + i), DW'(16'hBEEF ^ (i * 16'h0707)), 1'(i % 2),
               1 + (i % 3), 1 + (i % 2), 2, 1 + (i % 4), i % 3, 1'b0);
        end

        @(negedge clk);
        while (q.size() != 0 || in_op || gap_wait >= 0) @(negedge clk);
        repeat (5) @(negedge clk);
        check(req_ready && fl_ce_n, "R2 idle after last request", {req_ready, fl_ce_n}, 2'b11);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            nchk++;
            nerr++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule